// File: doc/BRIEF.md
# Saturating DSP Multiply-Accumulate Unit

This block carries out the signed DSP operations of a 32-bit RISC core's execute stage. It covers saturating add and subtract, the doubling variants of both, halfword-by-halfword multiplies, word-by-halfword fractional multiplies, and multiply-accumulates into either one 32-bit word or a 64-bit pair. Register read, instruction decode and condition evaluation take place upstream. The operands reach the block already read, together with an operation code and two halfword selects.

The result leaves on a 32-bit low word and a 32-bit high word. The high word is used only by the long accumulate and is zero for every other operation. A one-cycle `flag_o` pulse tells the core to set its sticky overflow bit. The pulse is raised only when a clamp or a signed overflow really happens. The parameter `OUT_REG` selects the timing: with `OUT_REG=1` (the default) all outputs are registered and appear one clock after the operands, and with `OUT_REG=0` the block is purely combinational.

Top module: `dspmac_unit`

## Requirements
- R1: Op 0 returns the saturated signed sum opa+opb. Op 1 returns the saturated signed difference opa−opb. An overflowing result clamps to 0x7FFF_FFFF (positive) or 0x8000_0000 (negative), and `flag_o` pulses only when that clamp occurs.
- R2: Op 2 and op 3 first double opb with saturation, then add that value to opa (op 2) or subtract it from opa (op 3), again with saturation. `flag_o` pulses if either step saturates.
- R3: A result that lands exactly on a limit value without saturating leaves `flag_o` low. This includes a doubling that gives exactly 0x8000_0000.
- R4: `sel_x_i`=1 takes opa[31:16] and 0 takes opa[15:0]. `sel_y_i` makes the same choice for opb. Each half is sign-extended before use. Op 7 returns the 32-bit product of the two halves and never pulses `flag_o`.
- R5: Op 4 adds `acc_i` to the halfword product with two's-complement wrap, and pulses `flag_o` on signed overflow of that addition.
- R6: Op 5 takes bits [47:16] of the signed product opa × (selected half of opb), adds `acc_i` with wrap, and pulses `flag_o` on signed overflow. Op 6 returns the same bits [47:16] alone and never pulses `flag_o`.
- R7: Op 8 adds the sign-extended halfword product to the 64-bit value {`acc_hi_i`,`acc_i`}. It returns the low word on `res_o` and the high word on `res_hi_o`, wraps at 64 bits, and never pulses `flag_o`.
- R8: `res_hi_o` is zero for every op other than 8.
- R9: With `OUT_REG=1`, outputs change only at a rising clock edge and reflect the operands present at that edge. A synchronous active-low reset clears `res_o`, `res_hi_o` and `flag_o`.
- R10: Op codes 9 to 15 give zero on both result words and never pulse `flag_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code (0..8 defined) |
| sel_x_i | input | 1 | Half select for opa (1 = upper) |
| sel_y_i | input | 1 | Half select for opb (1 = upper) |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| acc_i | input | 32 | Accumulator, or low word of the 64-bit accumulator |
| acc_hi_i | input | 32 | High word of the 64-bit accumulator |
| res_o | output | 32 | Result, or low word of the long result |
| res_hi_o | output | 32 | High word of the long result |
| flag_o | output | 1 | Sticky-overflow set pulse |

## Verification
The hardest cases to reach are those where saturation and the limit values separate. One is a doubling that lands exactly on 0x8000_0000 without clamping, after which the add or subtract overflows or does not. Another is an accumulate whose wrapped sum equals a limit value. The vector table places operands on both sides of each boundary, for example opb = 0xC000_0000 and 0x4000_0000 in the doubling ops, so that `flag_o` has to follow the overflow event and not the result value. Borrow and carry across the 64-bit word boundary, and the floor rounding of negative fractional products, are reached with small operands chosen to sit one unit from the word edges.

// File: rtl/dspmac_pkg.sv
// Shared operation encoding for the DSP multiply-accumulate unit.
// Assumes a 4-bit operation field; codes above OP_MLAL16 are undefined.
package dspmac_pkg;
    typedef enum logic [3:0] {
        OP_QADD   = 4'd0,
        OP_QSUB   = 4'd1,
        OP_QDADD  = 4'd2,
        OP_QDSUB  = 4'd3,
        OP_MLA16  = 4'd4,
        OP_MLAW   = 4'd5,
        OP_MULW   = 4'd6,
        OP_MUL16  = 4'd7,
        OP_MLAL16 = 4'd8
    } dsp_op_e;
endpackage

// File: rtl/dspmac_halfsel.sv
// Picks the upper or lower half of a word.
// Assumes DW is even; the caller sign-extends the returned half.
module dspmac_halfsel #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   word_i,
    input  logic            top_i,
    output logic [DW/2-1:0] half_o
);
    localparam int HW = DW / 2;

    // Half selection mux.
    always_comb begin
        half_o = top_i ? word_i[DW-1:HW] : word_i[HW-1:0];
    end
endmodule

// File: rtl/dspmac_satadd.sv
// Signed add or subtract that clamps to the most positive or most negative value.
// Assumes two's-complement operands; sat_o reports that a clamp happened.
module dspmac_satadd #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] lhs_i,
    input  logic [DW-1:0] rhs_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          sat_o
);
    localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MAX_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] ext;

    // One extra bit shows overflow as a mismatch of the top two bits.
    always_comb begin
        if (sub_i) ext = {lhs_i[DW-1], lhs_i} - {rhs_i[DW-1], rhs_i};
        else       ext = {lhs_i[DW-1], lhs_i} + {rhs_i[DW-1], rhs_i};
        sat_o = ext[DW] ^ ext[DW-1];
        if (sat_o) sum_o = ext[DW] ? MAX_NEG : MAX_POS;
        else       sum_o = ext[DW-1:0];
    end
endmodule

// File: rtl/dspmac_mults.sv
// Signed multipliers: halfword x halfword, and word x halfword keeping bits [DW+HW-1:HW].
// Assumes the halves arrive unextended; the sign extension is done here.
module dspmac_mults #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   word_i,
    input  logic [DW/2-1:0] half_a_i,
    input  logic [DW/2-1:0] half_b_i,
    output logic [DW-1:0]   prod16_o,
    output logic [DW-1:0]   frac_o
);
    localparam int HW = DW / 2;
    localparam int PW = DW + HW;

    logic signed [PW-1:0] wide;

    // Halfword product; its magnitude always fits DW bits.
    always_comb begin
        prod16_o = $signed({{HW{half_a_i[HW-1]}}, half_a_i}) *
                   $signed({{HW{half_b_i[HW-1]}}, half_b_i});
    end

    // Word by halfword product, arithmetic shift drops the low HW bits.
    always_comb begin
        wide   = $signed({{HW{word_i[DW-1]}}, word_i}) *
                 $signed({{DW{half_b_i[HW-1]}}, half_b_i});
        frac_o = DW'(wide >>> HW);
    end
endmodule

// File: rtl/dspmac_wrapadd.sv
// Two's-complement add that wraps and reports signed overflow.
// Assumes both inputs are signed values of the same width.
module dspmac_wrapadd #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] lhs_i,
    input  logic [DW-1:0] rhs_i,
    output logic [DW-1:0] sum_o,
    output logic          ovf_o
);
    // Overflow: operands share a sign and the sum has the other sign.
    always_comb begin
        sum_o = lhs_i + rhs_i;
        ovf_o = (lhs_i[DW-1] == rhs_i[DW-1]) && (sum_o[DW-1] != lhs_i[DW-1]);
    end
endmodule

// File: rtl/dspmac_unit.sv
// Saturating DSP multiply-accumulate unit.
// Runs one operation per cycle on operands that are already read. OUT_REG=1 adds
// one output register stage with synchronous active-low reset; OUT_REG=0 is combinational.
module dspmac_unit
    import dspmac_pkg::*;
#(
    parameter int DW      = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic          sel_x_i,
    input  logic          sel_y_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] acc_hi_i,
    output logic [DW-1:0] res_o,
    output logic [DW-1:0] res_hi_o,
    output logic          flag_o
);
    localparam int HW = DW / 2;

    dsp_op_e       op;
    logic [HW-1:0] half_a, half_b;
    logic [DW-1:0] prod16, frac;
    logic [DW-1:0] dbl, qrhs, qsum;
    logic          dbl_sat, qsat, is_dbl, is_sub;
    logic [DW-1:0] mla_sum, mlaw_sum;
    logic          mla_ovf, mlaw_ovf;
    logic [2*DW-1:0] long_sum;
    logic [DW-1:0] nxt_lo, nxt_hi;
    logic          nxt_flag;

    // Decode the operation code and the controls of the saturating path.
    always_comb begin
        op     = dsp_op_e'(op_i);
        is_dbl = (op == OP_QDADD) || (op == OP_QDSUB);
        is_sub = (op == OP_QSUB)  || (op == OP_QDSUB);
        qrhs   = is_dbl ? dbl : opb_i;
    end

    dspmac_halfsel #(.DW(DW)) u_sel_a (.word_i(opa_i), .top_i(sel_x_i), .half_o(half_a));
    dspmac_halfsel #(.DW(DW)) u_sel_b (.word_i(opb_i), .top_i(sel_y_i), .half_o(half_b));

    dspmac_mults #(.DW(DW)) u_mul (
        .word_i(opa_i), .half_a_i(half_a), .half_b_i(half_b),
        .prod16_o(prod16), .frac_o(frac)
    );

    dspmac_satadd #(.DW(DW)) u_dbl (
        .lhs_i(opb_i), .rhs_i(opb_i), .sub_i(1'b0), .sum_o(dbl), .sat_o(dbl_sat)
    );
    dspmac_satadd #(.DW(DW)) u_qsum (
        .lhs_i(opa_i), .rhs_i(qrhs), .sub_i(is_sub), .sum_o(qsum), .sat_o(qsat)
    );

    dspmac_wrapadd #(.DW(DW)) u_mla  (.lhs_i(prod16), .rhs_i(acc_i), .sum_o(mla_sum),  .ovf_o(mla_ovf));
    dspmac_wrapadd #(.DW(DW)) u_mlaw (.lhs_i(frac),   .rhs_i(acc_i), .sum_o(mlaw_sum), .ovf_o(mlaw_ovf));

    // 64-bit accumulate of the sign-extended halfword product.
    always_comb begin
        long_sum = {acc_hi_i, acc_i} + {{DW{prod16[DW-1]}}, prod16};
    end

    // Select the result words and the flag pulse for the operation.
    always_comb begin
        nxt_lo   = '0;
        nxt_hi   = '0;
        nxt_flag = 1'b0;
        case (op)
            OP_QADD, OP_QSUB: begin
                nxt_lo   = qsum;
                nxt_flag = qsat;
            end
            OP_QDADD, OP_QDSUB: begin
                nxt_lo   = qsum;
                nxt_flag = qsat | dbl_sat;
            end
            OP_MLA16: begin
                nxt_lo   = mla_sum;
                nxt_flag = mla_ovf;
            end
            OP_MLAW: begin
                nxt_lo   = mlaw_sum;
                nxt_flag = mlaw_ovf;
            end
            OP_MULW:  nxt_lo = frac;
            OP_MUL16: nxt_lo = prod16;
            OP_MLAL16: begin
                nxt_lo = long_sum[DW-1:0];
                nxt_hi = long_sum[2*DW-1:DW];
            end
            default: begin
                nxt_lo = '0;
            end
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            // Output stage, cleared by the synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_o    <= '0;
                    res_hi_o <= '0;
                    flag_o   <= 1'b0;
                end else begin
                    res_o    <= nxt_lo;
                    res_hi_o <= nxt_hi;
                    flag_o   <= nxt_flag;
                end
            end
        end else begin : g_comb
            assign res_o    = nxt_lo;
            assign res_hi_o = nxt_hi;
            assign flag_o   = nxt_flag;
        end
    endgenerate
endmodule

// File: rtl/dspmac_unit_chk.sv
// Property checker for dspmac_unit, attached with bind.
// Aligns the inputs with the outputs (one stage when OUT_REG=1) and checks relations at the ports.
module dspmac_unit_chk
    import dspmac_pkg::*;
#(
    parameter int DW      = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_i,
    input logic          sel_x_i,
    input logic          sel_y_i,
    input logic [DW-1:0] opa_i,
    input logic [DW-1:0] opb_i,
    input logic [DW-1:0] res_o,
    input logic [DW-1:0] res_hi_o,
    input logic          flag_o
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MAX_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [3:0]    op_s;
    logic          x_s, y_s, vld_s;
    logic [DW-1:0] a_s, b_s;
    logic [HW-1:0] ha_s, hb_s;

    generate
        if (OUT_REG) begin : g_align
            // Hold the inputs that produced the current outputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_s <= 1'b0;
                    op_s  <= '0;
                    x_s   <= 1'b0;
                    y_s   <= 1'b0;
                    a_s   <= '0;
                    b_s   <= '0;
                end else begin
                    vld_s <= 1'b1;
                    op_s  <= op_i;
                    x_s   <= sel_x_i;
                    y_s   <= sel_y_i;
                    a_s   <= opa_i;
                    b_s   <= opb_i;
                end
            end

            // R9: reset clears every output at the next edge.
            p_reset_clear_r9: assert property (@(posedge clk)
                !rst_n |=> (res_o == '0 && res_hi_o == '0 && !flag_o));
        end else begin : g_align
            assign vld_s = 1'b1;
            assign op_s  = op_i;
            assign x_s   = sel_x_i;
            assign y_s   = sel_y_i;
            assign a_s   = opa_i;
            assign b_s   = opb_i;
        end
    endgenerate

    assign ha_s = x_s ? a_s[DW-1:HW] : a_s[HW-1:0];
    assign hb_s = y_s ? b_s[DW-1:HW] : b_s[HW-1:0];

    // R4, R6, R7: the plain multiplies and the long accumulate never pulse the flag.
    p_quiet_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_s && (op_s == OP_MUL16 || op_s == OP_MULW || op_s == OP_MLAL16)) |-> !flag_o);

    // R1: a flagged saturating add/subtract always returns a limit value.
    p_limit_on_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_s && (op_s == OP_QADD || op_s == OP_QSUB) && flag_o) |->
        (res_o == MAX_POS || res_o == MAX_NEG));

    // R1: two non-negative operands never give a negative saturated sum.
    p_pos_no_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_s && op_s == OP_QADD && !a_s[DW-1] && !b_s[DW-1]) |-> !res_o[DW-1]);

    // R8: the high word is zero outside the long accumulate.
    p_hi_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_s && op_s != OP_MLAL16) |-> (res_hi_o == '0));

    // R10: undefined codes give zero and no flag.
    p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_s && op_s > 4'd8) |-> (res_o == '0 && res_hi_o == '0 && !flag_o));

    // R4: a zero selected half makes the halfword product zero.
    p_zero_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_s && op_s == OP_MUL16 && (ha_s == '0 || hb_s == '0)) |-> (res_o == '0));
endmodule

bind dspmac_unit dspmac_unit_chk #(.DW(DW), .OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_x_i(sel_x_i), .sel_y_i(sel_y_i),
    .opa_i(opa_i), .opb_i(opb_i), .res_o(res_o), .res_hi_o(res_hi_o), .flag_o(flag_o)
);

// File: tb/dspmac_unit_bench.sv
// Self-checking bench for dspmac_unit (OUT_REG=1): vector table walk plus directed tests.
module dspmac_unit_bench;
    typedef struct packed {
        logic [3:0]  op;
        logic        x;
        logic        y;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] acc;
        logic [31:0] acch;
        logic [31:0] elo;
        logic [31:0] ehi;
        logic        ef;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        // R1 saturating add/subtract
        '{4'd0,1'b0,1'b0,32'h7FFFFFF0,32'h00000020,32'h0,32'h0,32'h7FFFFFFF,32'h0,1'b1,8'd1},
        '{4'd0,1'b0,1'b0,32'h00000005,32'h00000007,32'h0,32'h0,32'h0000000C,32'h0,1'b0,8'd1},
        '{4'd1,1'b0,1'b0,32'h80000000,32'h00000001,32'h0,32'h0,32'h80000000,32'h0,1'b1,8'd1},
        '{4'd1,1'b0,1'b0,32'h0000000A,32'h00000003,32'h0,32'h0,32'h00000007,32'h0,1'b0,8'd1},
        // R3 exact limits without saturation
        '{4'd0,1'b0,1'b0,32'h7FFFFFFF,32'h00000000,32'h0,32'h0,32'h7FFFFFFF,32'h0,1'b0,8'd3},
        '{4'd1,1'b0,1'b0,32'h80000001,32'h00000001,32'h0,32'h0,32'h80000000,32'h0,1'b0,8'd3},
        // R2 doubling forms
        '{4'd2,1'b0,1'b0,32'h00000001,32'h40000000,32'h0,32'h0,32'h7FFFFFFF,32'h0,1'b1,8'd2},
        '{4'd2,1'b0,1'b0,32'h00000100,32'h00000010,32'h0,32'h0,32'h00000120,32'h0,1'b0,8'd2},
        '{4'd3,1'b0,1'b0,32'h00000000,32'hC0000000,32'h0,32'h0,32'h7FFFFFFF,32'h0,1'b1,8'd2},
        '{4'd3,1'b0,1'b0,32'hFFFFFFFB,32'h00000003,32'h0,32'h0,32'hFFFFFFF5,32'h0,1'b0,8'd2},
        '{4'd2,1'b0,1'b0,32'hFFFFFFFF,32'h50000000,32'h0,32'h0,32'h7FFFFFFE,32'h0,1'b1,8'd2},
        // R3 doubling that lands exactly on the negative limit
        '{4'd2,1'b0,1'b0,32'h00000000,32'hC0000000,32'h0,32'h0,32'h80000000,32'h0,1'b0,8'd3},
        // R4 half selects and plain halfword multiply
        '{4'd7,1'b0,1'b0,32'h0003FFFE,32'h00050004,32'h0,32'h0,32'hFFFFFFF8,32'h0,1'b0,8'd4},
        '{4'd7,1'b1,1'b1,32'h0003FFFE,32'h00050004,32'h0,32'h0,32'h0000000F,32'h0,1'b0,8'd4},
        '{4'd7,1'b1,1'b0,32'h0003FFFE,32'h00050004,32'h0,32'h0,32'h0000000C,32'h0,1'b0,8'd4},
        '{4'd7,1'b0,1'b1,32'h0003FFFE,32'h00050004,32'h0,32'h0,32'hFFFFFFF6,32'h0,1'b0,8'd4},
        '{4'd7,1'b0,1'b0,32'h00008000,32'h00008000,32'h0,32'h0,32'h40000000,32'h0,1'b0,8'd4},
        // R5 halfword multiply-accumulate
        '{4'd4,1'b0,1'b0,32'h00000010,32'h00000010,32'h7FFFFF00,32'h0,32'h80000000,32'h0,1'b1,8'd5},
        '{4'd4,1'b1,1'b0,32'hFFFF0000,32'h00000007,32'h00000064,32'h0,32'h0000005D,32'h0,1'b0,8'd5},
        '{4'd4,1'b0,1'b0,32'h0000FF00,32'h00000001,32'h80000000,32'h0,32'h7FFFFF00,32'h0,1'b1,8'd5},
        // R6 fractional word-by-half forms
        '{4'd5,1'b0,1'b0,32'h00010000,32'h00000003,32'h0000000A,32'h0,32'h0000000D,32'h0,1'b0,8'd6},
        '{4'd5,1'b0,1'b1,32'hFFFF0000,32'h00020000,32'h00000000,32'h0,32'hFFFFFFFE,32'h0,1'b0,8'd6},
        '{4'd5,1'b0,1'b0,32'h7FFFFFFF,32'h00007FFF,32'h40008001,32'h0,32'h80000000,32'h0,1'b1,8'd6},
        '{4'd5,1'b0,1'b0,32'h00000001,32'h0000FFFF,32'h00000000,32'h0,32'hFFFFFFFF,32'h0,1'b0,8'd6},
        '{4'd6,1'b0,1'b0,32'h7FFFFFFF,32'h00007FFF,32'h12345678,32'h0,32'h3FFF7FFF,32'h0,1'b0,8'd6},
        '{4'd6,1'b0,1'b0,32'h80000000,32'h00008000,32'h0,32'h0,32'h40000000,32'h0,1'b0,8'd6},
        // R7 long accumulate
        '{4'd8,1'b0,1'b0,32'h0000FFFF,32'h00000001,32'h00000000,32'h00000000,32'hFFFFFFFF,32'hFFFFFFFF,1'b0,8'd7},
        '{4'd8,1'b0,1'b0,32'h00007FFF,32'h00007FFF,32'hFFFFFFFF,32'h00000001,32'h3FFF0000,32'h00000002,1'b0,8'd7},
        '{4'd8,1'b0,1'b0,32'h0000FFFE,32'h00000001,32'h00000001,32'h00000005,32'hFFFFFFFF,32'h00000004,1'b0,8'd7},
        '{4'd8,1'b0,1'b0,32'h00000001,32'h00000001,32'hFFFFFFFF,32'h7FFFFFFF,32'h00000000,32'h80000000,1'b0,8'd7},
        '{4'd8,1'b1,1'b1,32'hFFFF0000,32'h00020000,32'h00000000,32'h00000000,32'hFFFFFFFE,32'hFFFFFFFF,1'b0,8'd7},
        // R10 undefined codes
        '{4'd9,1'b0,1'b0,32'h7FFFFFF0,32'h00000020,32'h11111111,32'h22222222,32'h0,32'h0,1'b0,8'd10},
        '{4'd15,1'b1,1'b1,32'h00050005,32'h00030003,32'h33333333,32'h44444444,32'h0,32'h0,1'b0,8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        sel_x_i = 1'b0, sel_y_i = 1'b0;
    logic [31:0] opa_i = '0, opb_i = '0, acc_i = '0, acc_hi_i = '0;
    logic [31:0] res_o, res_hi_o;
    logic        flag_o;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    dspmac_unit u_dspmac_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_x_i(sel_x_i), .sel_y_i(sel_y_i),
        .opa_i(opa_i), .opb_i(opb_i), .acc_i(acc_i), .acc_hi_i(acc_hi_i),
        .res_o(res_o), .res_hi_o(res_hi_o), .flag_o(flag_o)
    );

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_i = v.op; sel_x_i = v.x; sel_y_i = v.y;
        opa_i = v.a; opb_i = v.b; acc_i = v.acc; acc_hi_i = v.acch;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check32("R9", "reset res_o", res_o, 32'h0);
        check32("R9", "reset res_hi_o", res_hi_o, 32'h0);
        check32("R9", "reset flag_o", {31'b0, flag_o}, 32'h0);
        rst_n = 1'b1;

        // R9: latency, nothing moves before the rising edge
        @(negedge clk);
        drive(VECS[0]);
        #5;
        check32("R9", "pre-edge res_o", res_o, 32'h0);
        check32("R9", "pre-edge flag_o", {31'b0, flag_o}, 32'h0);
        @(negedge clk);
        check32("R9", "post-edge res_o", res_o, 32'h7FFFFFFF);
        check32("R1", "post-edge flag_o", {31'b0, flag_o}, 32'h1);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d#%0d", VECS[i].req, i);
            drive(VECS[i]);
            @(negedge clk);
            check32(rq, "res_o", res_o, VECS[i].elo);
            check32(rq, "res_hi_o (R8)", res_hi_o, VECS[i].ehi);
            check32(rq, "flag_o", {31'b0, flag_o}, {31'b0, VECS[i].ef});
        end

        // R4: flag pulses for one cycle only, drops on a following plain multiply
        drive(VECS[0]);
        @(negedge clk);
        drive(VECS[12]);
        @(negedge clk);
        check32("R4", "flag after saturate then mul", {31'b0, flag_o}, 32'h0);

        // R9: mid-run reset clears outputs while operands stay nonzero
        drive(VECS[27]);
        @(negedge clk);
        check32("R7", "pre-reset res_hi_o", res_hi_o, 32'h2);
        rst_n = 1'b0;
        @(negedge clk);
        check32("R9", "mid reset res_o", res_o, 32'h0);
        check32("R9", "mid reset res_hi_o", res_hi_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R9", "after reset res_lo", res_o, 32'h3FFF0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule